// File: doc/BRIEF.md
# Initiator Bus Request Controller

This block sits at one port of a bridge and decides when that port asks the shared bus for ownership and when it may begin a transaction as initiator. It watches how many upstream entries wait in the queues (posted writes and delayed requests) and whether the entry at the head has been written in full. It also watches the termination status of the transactions it started and an active-low grant. From these it drives an active-low request, a one-cycle start strobe for the data-phase sequencer, and a park enable. While park enable is high the port drives its address/data and command/byte-enable lines to a fixed all-zero pattern. The parity enable and value follow one clock later.

After a retry, a disconnect or a target abort on one of its own transactions, the port withdraws its request for exactly two clocks before it may ask again. When the bus is parked at the port and work becomes ready, the port may start at once, provided grant was present on the preceding clock. A locked posted write that ends in an abort cannot report that status to its initiator. The block flags it with a one-clock active-low system-error pulse, gated by an enable and, for master aborts, by a mode bit.

Top module: `pci_init_req_ctrl`

## Requirements
- R1: While reset is applied, and for two clocks after its release, req_n and serr_n are 1 and start, park_en and par_oe are 0.
- R2: When idle, req_n goes low one clock after pend_cnt is nonzero, head_done is 1 and no back-off is running. Once a transaction has started, req_n stays low until its status arrives on term_valid, whatever the queue count does.
- R3: With head_done at 0 the port does not request, even when pend_cnt is nonzero.
- R4: A status on term_valid for a started transaction with term_code 1 (retry), 2 (disconnect) or 3 (target abort) forces req_n high for exactly the next two clocks. Code 0 (normal) and code 4 (master abort) cause no back-off.
- R5: start is a one-clock pulse. It rises the clock after grant is sampled low while req_n is low and the entry is still ready. The port then counts as busy.
- R6: park_en is high in the clock after an idle port sees gnt_n low while req_n is high and no start is being taken.
- R7: par_oe repeats park_en one clock later. par carries the even parity of the parked address/data and command/byte-enable pattern, which is 0 for the all-zero pattern.
- R8: When park_en is high and an entry becomes ready while gnt_n is low, start pulses on the next clock without first asserting the request.
- R9: serr_n pulses low for one clock after the status of a started, locked, posted transaction. This happens for term_code 3 when serr_en is 1, and for term_code 4 only when both serr_en and ma_mode are 1.
- R10: No serr_n pulse is produced for aborts of transactions that are not locked, not posted, or when serr_en is 0.
- R11: term_valid has no effect while no transaction is in progress: no back-off and no error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_cnt | input | CNT_W | Number of queued upstream entries |
| head_done | input | 1 | Head entry fully written into its queue |
| gnt_n | input | 1 | Active-low bus grant |
| term_valid | input | 1 | Termination status of own transaction is valid |
| term_code | input | 3 | 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| term_locked | input | 1 | Terminated transaction was locked |
| term_posted | input | 1 | Terminated transaction was a posted write |
| serr_en | input | 1 | System-error reporting enable |
| ma_mode | input | 1 | Report master aborts as system errors |
| req_n | output | 1 | Active-low bus request |
| start | output | 1 | One-clock strobe: begin transaction as initiator |
| park_en | output | 1 | Drive address/data and command/byte-enable to the park pattern |
| par_oe | output | 1 | Drive parity line |
| par | output | 1 | Parity value for the parked pattern |
| serr_n | output | 1 | Active-low one-clock system-error pulse |

## Verification
The hardest situation to reach is a start taken straight from the parked state. The port must first be idle with an empty queue while grant is held low, so that parking occurs. An entry must then become ready while grant stays low, so the start is taken without the request ever dropping. The directed sequence drains the queue, waits for the request to fall away, lowers grant and checks parking and the delayed parity enable. It then raises the queue count with grant still held. A random phase afterwards mixes grants, statuses and queue states, and a behavioural model checks every output on every clock.

// File: rtl/pci_req_pkg.sv
package pci_req_pkg;

  typedef enum logic [2:0] {
    TERM_OK     = 3'd0,
    TERM_RETRY  = 3'd1,
    TERM_DISC   = 3'd2,
    TERM_TABORT = 3'd3,
    TERM_MABORT = 3'd4
  } term_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } init_st_e;

  function automatic logic is_backoff(input logic [2:0] code);
    return (code == TERM_RETRY) || (code == TERM_DISC) || (code == TERM_TABORT);
  endfunction

endpackage

// File: rtl/pci_req_backoff.sv
module pci_req_backoff #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic blocked
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LOADV = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = LOADV;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign blocked = (cnt_q != '0);
endmodule

// File: rtl/pci_park_parity.sv
module pci_park_parity #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter logic [AD_W-1:0]  PARK_AD  = '0,
  parameter logic [CBE_W-1:0] PARK_CBE = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic park_en,
  output logic par_oe,
  output logic par
);
  localparam int TOT_W = AD_W + CBE_W;
  localparam logic [TOT_W-1:0] PAT = {PARK_AD, PARK_CBE};

  logic [TOT_W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < TOT_W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ PAT[i];
  end

  logic oe_d, par_d;
  always_comb begin
    oe_d  = park_en;
    par_d = par;
    if (park_en) par_d = chain[TOT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_oe <= 1'b0;
      par    <= 1'b0;
    end else begin
      par_oe <= oe_d;
      par    <= par_d;
    end
  end
endmodule

// File: rtl/pci_serr_gen.sv
module pci_serr_gen
  import pci_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin,
  input  logic [2:0] code,
  input  logic       locked,
  input  logic       posted,
  input  logic       serr_en,
  input  logic       ma_mode,
  output logic       serr_n
);
  logic hit;
  always_comb begin
    hit = 1'b0;
    if (fin && locked && posted && serr_en) begin
      if (code == TERM_TABORT)                  hit = 1'b1;
      else if (code == TERM_MABORT && ma_mode)  hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_n <= 1'b1;
    else        serr_n <= ~hit;
  end
endmodule

// File: rtl/pci_init_req_ctrl.sv
module pci_init_req_ctrl
  import pci_req_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int BACKOFF = 2,
  parameter logic [AD_W-1:0]  PARK_AD  = '0,
  parameter logic [CBE_W-1:0] PARK_CBE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             head_done,
  input  logic             gnt_n,
  input  logic             term_valid,
  input  logic [2:0]       term_code,
  input  logic             term_locked,
  input  logic             term_posted,
  input  logic             serr_en,
  input  logic             ma_mode,
  output logic             req_n,
  output logic             start,
  output logic             park_en,
  output logic             par_oe,
  output logic             par,
  output logic             serr_n
);
  // reset: asynchronous assertion, synchronous release
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  init_st_e state_q, state_d;
  logic req_q, req_d, start_q, start_d, park_q, park_d;
  logic bo_blocked, ready, fin, bo_evt, busy;

  assign busy   = (state_q == ST_BUSY);
  assign fin    = busy && term_valid;
  assign bo_evt = fin && is_backoff(term_code);
  assign ready  = (pend_cnt != '0) && head_done && !bo_blocked;

  pci_req_backoff #(.HOLD(BACKOFF)) i_backoff (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (bo_evt),
    .blocked (bo_blocked)
  );

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    start_d = 1'b0;
    park_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        start_d = !gnt_n && ready && (req_q || park_q);
        req_d   = ready;
        park_d  = !gnt_n && !req_q && !start_d;
        if (start_d) state_d = ST_BUSY;
      end
      ST_BUSY: begin
        if (fin) begin
          state_d = ST_IDLE;
          req_d   = !bo_evt && ready;
        end else begin
          req_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      start_q <= 1'b0;
      park_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      start_q <= start_d;
      park_q  <= park_d;
    end
  end

  pci_park_parity #(
    .AD_W(AD_W), .CBE_W(CBE_W), .PARK_AD(PARK_AD), .PARK_CBE(PARK_CBE)
  ) i_parity (
    .clk     (clk),
    .rst_n   (rst_i),
    .park_en (park_q),
    .par_oe  (par_oe),
    .par     (par)
  );

  pci_serr_gen i_serr (
    .clk     (clk),
    .rst_n   (rst_i),
    .fin     (fin),
    .code    (term_code),
    .locked  (term_locked),
    .posted  (term_posted),
    .serr_en (serr_en),
    .ma_mode (ma_mode),
    .serr_n  (serr_n)
  );

  assign req_n   = ~req_q;
  assign start   = start_q;
  assign park_en = park_q;
endmodule

// File: rtl/pci_init_req_chk.sv
module pci_init_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gnt_n,
  input logic       head_done,
  input logic       term_valid,
  input logic [2:0] term_code,
  input logic       busy,
  input logic       req_n,
  input logic       start,
  input logic       park_en,
  input logic       par_oe,
  input logic       serr_n
);
  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  p_start_after_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(!gnt_n));

  p_backoff_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && term_valid && (term_code == 3'd1 || term_code == 3'd2 || term_code == 3'd3))
      |=> req_n ##1 req_n);

  p_unqueued_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !head_done) |=> req_n);

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !term_valid) |=> !req_n);

  p_par_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |=> par_oe);

  p_serr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |=> serr_n);

  p_idle_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && term_valid) |=> serr_n);
endmodule

bind pci_init_req_ctrl pci_init_req_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_i),
  .gnt_n      (gnt_n),
  .head_done  (head_done),
  .term_valid (term_valid),
  .term_code  (term_code),
  .busy       (busy),
  .req_n      (req_n),
  .start      (start),
  .park_en    (park_en),
  .par_oe     (par_oe),
  .serr_n     (serr_n)
);

// File: tb/test_pci_init_req_ctrl.sv
module test_pci_init_req_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pend_cnt = '0;
  logic head_done = 1'b0, gnt_n = 1'b1, term_valid = 1'b0;
  logic [2:0] term_code = '0;
  logic term_locked = 1'b0, term_posted = 1'b0, serr_en = 1'b0, ma_mode = 1'b0;
  logic req_n, start, park_en, par_oe, par, serr_n;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pci_init_req_ctrl i_pci_init_req_ctrl (
    .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .head_done(head_done),
    .gnt_n(gnt_n), .term_valid(term_valid), .term_code(term_code),
    .term_locked(term_locked), .term_posted(term_posted), .serr_en(serr_en),
    .ma_mode(ma_mode), .req_n(req_n), .start(start), .park_en(park_en),
    .par_oe(par_oe), .par(par), .serr_n(serr_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  sync_cnt, bo_left;
  bit  m_busy, m_req, m_start, m_park, m_paroe, m_serr;
  bit  n_ready, n_fin, n_boe, n_hit, n_start;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || sync_cnt < 2) begin
      if (!rst_n) sync_cnt = 0; else sync_cnt++;
      bo_left = 0; m_busy = 0; m_req = 0; m_start = 0; m_park = 0;
      m_paroe = 0; m_serr = 1;
    end else begin
      n_ready = (pend_cnt != 0) && head_done && (bo_left == 0);
      n_fin   = m_busy && term_valid;
      n_boe   = n_fin && (term_code >= 1 && term_code <= 3);
      n_hit   = n_fin && term_locked && term_posted && serr_en &&
                (term_code == 3 || (term_code == 4 && ma_mode));
      m_paroe = m_park;
      m_serr  = !n_hit;
      if (n_boe) bo_left = 1; else if (bo_left > 0) bo_left--;
      if (!m_busy) begin
        n_start = !gnt_n && n_ready && (m_req || m_park);
        m_park  = !gnt_n && !m_req && !n_start;
        m_req   = n_ready;
        m_start = n_start;
        m_busy  = n_start;
      end else begin
        m_start = 0;
        m_park  = 0;
        if (n_fin) begin
          m_busy = 0;
          m_req  = !n_boe && n_ready;
        end else m_req = 1;
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    chk("R1/R2/R3/R4/R8 req_n", req_n, !m_req);
    chk("R5/R8 start", start, m_start);
    chk("R6 park_en", park_en, m_park);
    chk("R7 par_oe", par_oe, m_paroe);
    chk("R7 par", par, 0);
    chk("R9/R10/R11 serr_n", serr_n, m_serr);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  // run one transaction from request to grant
  task automatic take_grant;
    gnt_n = 0; step();
    chk("R5 start rises", start, 1);
    gnt_n = 1; step();
    chk("R5 start one clock", start, 0);
    chk("R2 held while busy", req_n, 0);
  endtask

  task automatic end_txn(input int code, input bit lk, input bit ps);
    term_valid = 1; term_code = 3'(code); term_locked = lk; term_posted = ps;
    step();
    term_valid = 0; term_locked = 0; term_posted = 0;
  endtask

  initial begin
    step(3);
    chk("R1 req_n", req_n, 1); chk("R1 start", start, 0);
    chk("R1 park_en", park_en, 0); chk("R1 par_oe", par_oe, 0);
    chk("R1 serr_n", serr_n, 1);
    rst_n = 1; step(4);

    pend_cnt = 2; head_done = 0; step();
    for (int i = 0; i < 4; i++) begin chk("R3 no request unqueued", req_n, 1); step(); end
    head_done = 1; step();
    chk("R2 request raised", req_n, 0);
    take_grant();
    pend_cnt = 0; step(3);
    chk("R2 held with empty queue", req_n, 0);
    pend_cnt = 2;

    for (int c = 1; c <= 3; c++) begin
      end_txn(c, 0, 0);
      chk("R4 backoff clock 1", req_n, 1);
      step();
      chk("R4 backoff clock 2", req_n, 1);
      step();
      chk("R4 request again", req_n, 0);
      take_grant();
    end

    serr_en = 1; ma_mode = 1;
    end_txn(4, 1, 1);
    chk("R9 master abort pulse", serr_n, 0);
    chk("R4 no backoff on master abort", req_n, 0);
    step();
    chk("R9 pulse ends", serr_n, 1);
    take_grant();
    end_txn(3, 1, 0);
    chk("R10 non-posted no error", serr_n, 1);
    step(2); take_grant();
    end_txn(3, 0, 1);
    chk("R10 non-locked no error", serr_n, 1);
    step(2); take_grant();
    serr_en = 0;
    end_txn(3, 1, 1);
    chk("R10 disabled no error", serr_n, 1);
    serr_en = 1; ma_mode = 0;
    step(2); take_grant();
    end_txn(4, 1, 1);
    chk("R9 master abort needs mode", serr_n, 1);

    step();
    end_txn(1, 1, 1);
    chk("R11 idle status ignored req", req_n, 0);
    chk("R11 idle status ignored serr", serr_n, 1);
    step();
    chk("R11 no backoff", req_n, 0);

    pend_cnt = 0; step(2);
    chk("R2 request drops", req_n, 1);
    gnt_n = 0; step();
    chk("R6 parked", park_en, 1);
    chk("R7 parity not yet", par_oe, 0);
    step();
    chk("R7 parity enabled", par_oe, 1);
    chk("R7 parity value", par, 0);
    pend_cnt = 1; step();
    chk("R8 start from park", start, 1);
    chk("R6 park released", park_en, 0);
    gnt_n = 1; step();
    end_txn(0, 0, 0);
    step(2);

    for (int i = 0; i < 3000; i++) begin
      pend_cnt    = 4'($urandom_range(0, 3));
      head_done   = ($urandom_range(0, 3) != 0);
      gnt_n       = $urandom_range(0, 1);
      term_valid  = ($urandom_range(0, 3) == 0);
      term_code   = 3'($urandom_range(0, 4));
      term_locked = $urandom_range(0, 1);
      term_posted = $urandom_range(0, 1);
      serr_en     = $urandom_range(0, 1);
      ma_mode     = $urandom_range(0, 1);
      if (i == 1500) rst_n = 0;
      if (i == 1503) rst_n = 1;
      step();
    end
    step(2);
    finish_run();
  end
endmodule